// File: doc/BRIEF.md
# Processor Clock Source with Selective Prescaler

This block produces the clock for an embedded processor core. Four source clocks reach it as single-cycle tick strobes in the core clock domain. One of them is picked by a source select field. A shared post-divider then divides the picked source. Only source 3 first passes through an extra 5-bit prescaler; sources 0, 1 and 2 go straight to the post-divider. The result is a divided clock level, `cpu_clk_out`, and a strobe, `cpu_clk_stb`, that is high for one core cycle at the start of each output period.

A single 32-bit control word holds all settings. It is written and read back over a plain write-enable and data port. The source select sits in bits 17:16, the prescale value in bits 12:8 and the post-divide value in bits 5:4. A write only updates the pending word. The block moves the whole pending word into its active settings on the source tick that ends the current output period. A change of source or ratio therefore never cuts a period short.

The total ratio N counts ticks of the selected source. N is (prescale+1)·(postdiv+1) when source 3 is active and (postdiv+1) otherwise.

Top module: `cpuclk_gen`

## Requirements
- R1: While reset is asserted, `cfg_rd_data` reads 0 and both `cpu_clk_out` and `cpu_clk_stb` are low. After reset the block runs from source 0 with ratio 1.
- R2: The control word keeps only source select (bits 17:16), prescale (bits 12:8) and post-divide (bits 5:4). All other bits read as 0 and writes to them are ignored. A write shows on `cfg_rd_data` in the cycle after `cfg_wr_en`.
- R3: Only ticks of the source named by the active select advance the output. Ticks on the other three inputs are ignored.
- R4: For sources 0, 1 and 2, the output period is (postdiv+1) ticks of that source, whatever the prescale field holds.
- R5: For source 3, the output period is (prescale+1)·(postdiv+1) ticks, which covers ratios 1 to 128.
- R6: For N ≥ 2, the output is high for floor(N/2) source ticks and low for the rest, so even ratios give 50% duty and odd ratios are low one tick longer. For N = 1 the output stays high.
- R7: `cpu_clk_stb` pulses for one cycle at the first tick of every period. In that same cycle `cpu_clk_out` is high.
- R8: A new control word, including a new source, takes effect only at the next period boundary. The period in progress completes with its old settings.
- R9: `cpu_clk_out` and `cpu_clk_stb` change only in the cycle after a source tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; all logic is on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 4 | One tick strobe per source clock, bit i for source i |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wr_data | input | 32 | Control word to write |
| cfg_rd_data | output | 32 | Current pending control word, reserved bits zero |
| cpu_clk_out | output | 1 | Divided clock level |
| cpu_clk_stb | output | 1 | One-cycle strobe at each output period start |

## Verification
The bench builds the block with the default field widths: 2 select bits, 5 prescale bits and 2 post-divide bits. With these widths the top ratio of 128 and the odd-ratio duty cases can be reached within a short run. Each source ticks at a different rate (every 2, 3, 4 and 5 core cycles), so a wrong source choice shows up as a wrong period length. Each write is scheduled just after a period boundary. The bench then checks the period that is still running against the old settings and the next period against the new ones. This exposes any change that is applied before the boundary.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;

    localparam int DATA_W        = 32;
    localparam int SEL_W         = 2;
    localparam int PRE_W         = 5;
    localparam int POST_W        = 2;
    localparam int SEL_LSB       = 16;
    localparam int PRE_LSB       = 8;
    localparam int POST_LSB      = 4;
    localparam int NUM_SRC       = 1 << SEL_W;
    localparam int PRESCALED_SRC = NUM_SRC - 1;
    localparam int RATIO_W       = PRE_W + POST_W + 1;

    localparam logic [DATA_W-1:0] CFG_MASK =
        (DATA_W'((1 << SEL_W) - 1)  << SEL_LSB) |
        (DATA_W'((1 << PRE_W) - 1)  << PRE_LSB) |
        (DATA_W'((1 << POST_W) - 1) << POST_LSB);

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [PRE_W-1:0]  pre;
        logic [POST_W-1:0] post;
    } clk_cfg_t;

    typedef struct packed {
        logic [RATIO_W-1:0] total;
        logic [RATIO_W-1:0] last;
        logic [RATIO_W-1:0] high;
    } ratio_t;

    function automatic clk_cfg_t cfg_unpack(logic [DATA_W-1:0] word);
        clk_cfg_t c;
        c.sel  = word[SEL_LSB  +: SEL_W];
        c.pre  = word[PRE_LSB  +: PRE_W];
        c.post = word[POST_LSB +: POST_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_pack(clk_cfg_t c);
        logic [DATA_W-1:0] word;
        word = '0;
        word[SEL_LSB  +: SEL_W]  = c.sel;
        word[PRE_LSB  +: PRE_W]  = c.pre;
        word[POST_LSB +: POST_W] = c.post;
        return word;
    endfunction

    function automatic ratio_t ratio_of(clk_cfg_t c);
        ratio_t r;
        logic [RATIO_W-1:0] pre_part;
        logic [RATIO_W-1:0] post_part;
        pre_part  = (c.sel == SEL_W'(PRESCALED_SRC)) ?
                    RATIO_W'(c.pre) + RATIO_W'(1) : RATIO_W'(1);
        post_part = RATIO_W'(c.post) + RATIO_W'(1);
        r.total   = pre_part * post_part;
        r.last    = r.total - RATIO_W'(1);
        r.high    = r.total >> 1;
        return r;
    endfunction

endpackage

// File: rtl/cpuclk_regs.sv
module cpuclk_regs
    import cpuclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output clk_cfg_t          pend_cfg,
    output logic [DATA_W-1:0] rd_data
);

    clk_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= cfg_unpack(wr_data);
        end
    end

    assign pend_cfg = cfg_q;
    assign rd_data  = cfg_pack(cfg_q);

endmodule

// File: rtl/cpuclk_srcmux.sv
module cpuclk_srcmux
    import cpuclk_pkg::*;
(
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0]   sel,
    output logic               tick
);

    logic [NUM_SRC-1:0] hit;

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
        assign hit[gi] = src_tick[gi] && (sel == SEL_W'(gi));
    end

    assign tick = |hit;

endmodule

// File: rtl/cpuclk_phasegen.sv
module cpuclk_phasegen
    import cpuclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  clk_cfg_t         pend_cfg,
    output logic [SEL_W-1:0] act_sel,
    output logic             clk_out,
    output logic             period_stb
);

    clk_cfg_t           act_cfg;
    ratio_t             rat;
    logic [RATIO_W-1:0] phase;
    logic [RATIO_W-1:0] phase_nxt;

    assign rat       = ratio_of(act_cfg);
    assign phase_nxt = phase + RATIO_W'(1);
    assign act_sel   = act_cfg.sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_cfg    <= '0;
            phase      <= '0;
            clk_out    <= 1'b0;
            period_stb <= 1'b0;
        end else begin
            period_stb <= 1'b0;
            if (tick) begin
                if (phase == rat.last) begin
                    // boundary: adopt pending settings, start a high phase
                    phase      <= '0;
                    act_cfg    <= pend_cfg;
                    clk_out    <= 1'b1;
                    period_stb <= 1'b1;
                end else begin
                    phase   <= phase_nxt;
                    clk_out <= (phase_nxt < rat.high);
                end
            end
        end
    end

endmodule

// File: rtl/cpuclk_gen.sv
module cpuclk_gen
    import cpuclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               cfg_wr_en,
    input  logic [DATA_W-1:0]  cfg_wr_data,
    output logic [DATA_W-1:0]  cfg_rd_data,
    output logic               cpu_clk_out,
    output logic               cpu_clk_stb
);

    clk_cfg_t         pend_cfg;
    logic [SEL_W-1:0] act_sel;
    logic             sel_tick;

    cpuclk_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr_en),
        .wr_data  (cfg_wr_data),
        .pend_cfg (pend_cfg),
        .rd_data  (cfg_rd_data)
    );

    cpuclk_srcmux u_mux (
        .src_tick (src_tick),
        .sel      (act_sel),
        .tick     (sel_tick)
    );

    cpuclk_phasegen u_phase (
        .clk        (clk),
        .rst        (rst),
        .tick       (sel_tick),
        .pend_cfg   (pend_cfg),
        .act_sel    (act_sel),
        .clk_out    (cpu_clk_out),
        .period_stb (cpu_clk_stb)
    );

endmodule

// File: rtl/cpuclk_gen_chk.sv
module cpuclk_gen_chk
    import cpuclk_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] src_tick,
    input logic               cfg_wr_en,
    input logic [DATA_W-1:0]  cfg_rd_data,
    input logic               cpu_clk_out,
    input logic               cpu_clk_stb
);

    a_r7_stb_with_high: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_stb |-> cpu_clk_out);

    a_r9_quiet_without_tick: assert property (@(posedge clk) disable iff (rst)
        !$past(|src_tick) |-> ($stable(cpu_clk_out) && !cpu_clk_stb));

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd_data & ~CFG_MASK) == '0);

    a_r2_rd_after_write: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_wr_en) |-> $stable(cfg_rd_data));

endmodule

bind cpuclk_gen cpuclk_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .src_tick    (src_tick),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_rd_data (cfg_rd_data),
    .cpu_clk_out (cpu_clk_out),
    .cpu_clk_stb (cpu_clk_stb)
);

// File: tb/cpuclk_gen_tb.sv
module cpuclk_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  src_tick = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        clk_out;
    logic        clk_stb;

    always #2 clk = ~clk;

    cpuclk_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .src_tick    (src_tick),
        .cfg_wr_en   (wr_en),
        .cfg_wr_data (wr_data),
        .cfg_rd_data (rd_data),
        .cpu_clk_out (clk_out),
        .cpu_clk_stb (clk_stb)
    );

    typedef struct {
        int    n;
        int    hi;
        string req;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    bit   done = 0;
    event stb_ev;

    int   sh_sel = 0, sh_pre = 0, sh_post = 0;
    int   active_sel = 0;
    int   n_meas = 0, hi_meas = 0;
    bit   started = 0;
    bit   glitch = 0;
    logic prev_out = 1'b0;
    logic [3:0] last_tick = '0;
    int   cnt [4] = '{0, 0, 0, 0};

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_n(int s, int p, int o);
        return (s == 3) ? (p + 1) * (o + 1) : (o + 1);
    endfunction

    function automatic int exp_hi(int n);
        return (n == 1) ? 1 : n / 2;
    endfunction

    // monitor (scoreboard pop) and source tick generation, at the falling edge
    always @(negedge clk) begin
        if (rst) begin
            started = 0;
            active_sel = 0;
            glitch = 0;
        end else begin
            if (clk_stb) begin
                check(clk_out == 1'b1, "R7", "out at period start", clk_out, 1);
                if (started && q.size() > 0) begin
                    exp_t e;
                    e = q.pop_front();
                    check(n_meas == e.n, {e.req, " R3"}, "period ticks", n_meas, e.n);
                    check(hi_meas == e.hi, {e.req, " R6"}, "high ticks", hi_meas, e.hi);
                    check(!glitch, "R9", "change without tick", glitch, 0);
                end
                started = 1;
                glitch = 0;
                active_sel = sh_sel;
                n_meas = 1;
                hi_meas = clk_out ? 1 : 0;
                -> stb_ev;
            end else if (started) begin
                if (last_tick[active_sel]) begin
                    n_meas++;
                    if (clk_out) hi_meas++;
                end else if (clk_out != prev_out) begin
                    glitch = 1;
                end
            end
        end
        prev_out = clk_out;
        for (int i = 0; i < 4; i++) begin
            cnt[i]++;
            if (cnt[i] == i + 2) begin
                cnt[i] = 0;
                last_tick[i] = 1'b1;
            end else begin
                last_tick[i] = 1'b0;
            end
        end
        src_tick = last_tick;
    end

    // driver: write right after a boundary, push old-then-new expectations
    task automatic run(int s, int p, int o, string old_req, string new_req);
        exp_t eo, en;
        @(stb_ev);
        eo.n = exp_n(sh_sel, sh_pre, sh_post);
        eo.hi = exp_hi(eo.n);
        eo.req = old_req;
        en.n = exp_n(s, p, o);
        en.hi = exp_hi(en.n);
        en.req = new_req;
        wr_en = 1'b1;
        wr_data = (s << 16) | (p << 8) | (o << 4);
        sh_sel = s; sh_pre = p; sh_post = o;
        q.push_back(eo);
        q.push_back(en);
        @(negedge clk);
        wr_en = 1'b0;
        wait (q.size() == 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(rd_data == 32'h0, "R1", "rd_data in reset", rd_data, 0);
        check(clk_out == 1'b0, "R1", "out in reset", clk_out, 0);
        check(clk_stb == 1'b0, "R1", "stb in reset", clk_stb, 0);
        rst = 1'b0;

        // source 1, prescale field set but ignored: N=3
        run(1, 9, 2, "R1", "R4");

        // reserved bits and readback: all-ones keeps only the three fields
        @(stb_ev);
        wr_en = 1'b1;
        wr_data = 32'hFFFF_FFFF;
        sh_sel = 3; sh_pre = 31; sh_post = 3;
        @(negedge clk);
        wr_en = 1'b0;
        check(rd_data == 32'h0003_1F30, "R2", "masked readback", rd_data, 32'h0003_1F30);

        run(2, 0, 3, "R5", "R4");   // old: N=128 from source 3
        run(3, 4, 1, "R8", "R5");   // N=10
        run(0, 5, 1, "R8", "R4");   // N=2, prescale ignored
        run(3, 0, 0, "R8", "R5");   // N=1
        run(3, 6, 2, "R8", "R6");   // N=21, odd ratio
        check(rd_data == 32'h0003_0620, "R2", "final readback", rd_data, 32'h0003_0620);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R8 watchdog: got %0d pending expected %0d", q.size(), 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule